// File: doc/BRIEF.md
# Secure Low-Power Real-Time Clock with Alarm

This peripheral keeps time in a slow, always-on clock domain and is managed through a 32-bit register port on a fast bus clock. It holds a 32-bit seconds count, a free-running sub-second count, an alarm compare value, a control word and a glitch-detector key. Time only advances after two exits in order. First the block leaves its init state. It then leaves its non-valid state, and that exit needs the correct key. When the seconds count reaches the alarm value, a sticky flag is raised. That flag drives an interrupt output and a wake-up output, and each of these has its own enable bit.

Writes use a valid/ready handshake. The bus holds `wr_valid`, `wr_addr` and `wr_data` steady until it sees `wr_ready` high at a rising `bus_clk` edge. `wr_ready` drops for the whole time one write is in flight to the slow domain, which takes about three slow-clock cycles plus a short return trip. Reads are combinational on `rd_addr`. They return a snapshot that the slow domain refreshes every few slow cycles, so a value read back lags the slow-domain state by that amount. `rst_n` resets both domains asynchronously. The system must release it cleanly with respect to both clocks.

Top module: `lp_rtc`

## Requirements
- R1: After reset, the seconds (0x00), alarm (0x08), control (0x10), status (0x14) and key (0x18) registers all read zero, and `irq` and `wake` are low. A control write reads back masked to its defined bits: 3, 4, 7, 11, 14 and 15.
- R2: `wr_ready` is low from the cycle after a write is accepted until that write has landed in the slow domain. Status bit 0 reads 1 during this time. A write held pending through back-pressure is accepted later and takes effect.
- R3: Control bit 15 moves the block from init to non-valid, and status bit 15 then reads 1. While the block is still in init, control bit 14 has no effect.
- R4: The block moves from non-valid to valid, and status bit 14 reads 1, only when control bit 14 is set and register 0x18 holds 0x41736166. Any other key keeps status bit 14 at 0.
- R5: A write to 0x00 loads the seconds count, which reads back as the same 32-bit value. The count stays fixed unless the block is valid and control bit 3 is set.
- R6: When the block is valid and control bit 3 is set, the seconds count increments once per 2^SUB_W slow cycles and wraps from 0xFFFFFFFF to 0.
- R7: The sub-second count at 0x04 advances every slow cycle modulo 2^SUB_W. Writes to 0x04 are ignored.
- R8: Status bit 3, the alarm flag, is set when the block is valid and the seconds count equals the alarm value. It then stays set after the count moves on. It never sets before the block is valid.
- R9: Writing status with bit 3 set clears the alarm flag, unless a match occurs in the same cycle. Writing zero leaves the flag as it is. Status bits 14 and 15 follow the lifecycle and are not cleared.
- R10: `irq` equals the alarm flag AND control bit 7. `wake` equals the alarm flag AND control bit 4.
- R11: The lifecycle only moves forward, from init to non-valid to valid. Once valid, the block stays valid until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Fast register-port clock |
| lp_clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted when high with wr_valid |
| wr_addr | input | 5 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read byte offset |
| rd_data | output | 32 | Read data from the latest snapshot |
| irq | output | 1 | Alarm interrupt |
| wake | output | 1 | Alarm wake-up request |

## Verification
Any fault in the lifecycle sequencer shows at the ports. Status bits 14 and 15 are wrong within one snapshot period, about ten slow cycles, after the control or key write that should have caused the exit. A fault in the seconds counter or in its run gating shows up as a stuck count, a drifting count or a count that will not load, once a few seconds have been waited out. A fault in the alarm flag appears on `irq` or `wake` within one slow cycle of the match or of the clearing write. A fault in the crossing logic shows as `wr_ready` stuck low, or as writes that are lost or applied twice.

// File: rtl/lp_rtc_pkg.sv
package lp_rtc_pkg;
  localparam int AW = 5;
  localparam logic [AW-1:0] OFS_SECS  = 5'h00;
  localparam logic [AW-1:0] OFS_SUB   = 5'h04;
  localparam logic [AW-1:0] OFS_ALARM = 5'h08;
  localparam logic [AW-1:0] OFS_CTRL  = 5'h10;
  localparam logic [AW-1:0] OFS_STAT  = 5'h14;
  localparam logic [AW-1:0] OFS_KEY   = 5'h18;

  localparam int C_CNT_EN     = 3;
  localparam int C_WAKE_EN    = 4;
  localparam int C_IRQ_EN     = 7;
  localparam int C_NSEC       = 11;
  localparam int C_LEAVE_NV   = 14;
  localparam int C_LEAVE_INIT = 15;
  localparam logic [15:0] CTRL_MASK = 16'hC898;

  localparam int S_BUSY      = 0;
  localparam int S_ALARM     = 3;
  localparam int S_NV_DONE   = 14;
  localparam int S_INIT_DONE = 15;

  localparam logic [31:0] GLITCH_KEY = 32'h4173_6166;

  typedef enum logic [1:0] {
    LC_INIT     = 2'd0,
    LC_NONVALID = 2'd1,
    LC_VALID    = 2'd2
  } lc_e;
endpackage

// File: rtl/lp_rtc_xfer.sv
module lp_rtc_xfer #(
  parameter int W = 8
) (
  input  logic         src_clk,
  input  logic         dst_clk,
  input  logic         rst_n,
  input  logic         src_valid,
  output logic         src_busy,
  input  logic [W-1:0] src_data,
  output logic         dst_pulse,
  output logic [W-1:0] dst_data
);
  logic [W-1:0] hold_q;
  logic         req_q, ack_s1, ack_s2;
  logic         req_d1, req_d2, req_d3;

  assign src_busy = req_q ^ ack_s2;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      req_q  <= 1'b0;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= req_d3;
      ack_s2 <= ack_s1;
      if (src_valid && !src_busy) begin
        hold_q <= src_data;
        req_q  <= ~req_q;
      end
    end
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d1 <= 1'b0;
      req_d2 <= 1'b0;
      req_d3 <= 1'b0;
    end else begin
      req_d1 <= req_q;
      req_d2 <= req_d1;
      req_d3 <= req_d2;
    end
  end

  assign dst_pulse = req_d2 ^ req_d3;
  assign dst_data  = hold_q;

  // R2: the payload must not move while the destination may still sample it
  assert_hold_stable_R2: assert property (@(posedge src_clk) disable iff (!rst_n)
    (src_busy && $past(src_busy)) |-> $stable(hold_q));
endmodule

// File: rtl/lp_rtc_core.sv
module lp_rtc_core
  import lp_rtc_pkg::*;
#(
  parameter int SUB_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_pulse,
  input  logic [AW-1:0]    wr_addr,
  input  logic [31:0]      wr_data,
  output logic [31:0]      secs_o,
  output logic [SUB_W-1:0] sub_o,
  output logic [31:0]      alarm_o,
  output logic [15:0]      ctrl_o,
  output logic [31:0]      key_o,
  output logic             init_done_o,
  output logic             nv_done_o,
  output logic             alarm_flag_o,
  output logic             irq_o,
  output logic             wake_o
);
  lc_e              state_q, state_d;
  logic [31:0]      secs_q, alarm_q, key_q;
  logic [SUB_W-1:0] sub_q;
  logic [15:0]      ctrl_q;
  logic             alp_q;
  logic             ld_secs, ld_alarm, ld_ctrl, ld_key, clr_alp;
  logic             run, wrap, match;

  assign ld_secs  = wr_pulse && (wr_addr == OFS_SECS);
  assign ld_alarm = wr_pulse && (wr_addr == OFS_ALARM);
  assign ld_ctrl  = wr_pulse && (wr_addr == OFS_CTRL);
  assign ld_key   = wr_pulse && (wr_addr == OFS_KEY);
  assign clr_alp  = wr_pulse && (wr_addr == OFS_STAT) && wr_data[S_ALARM];

  assign wrap  = &sub_q;
  assign run   = (state_q == LC_VALID) && ctrl_q[C_CNT_EN];
  assign match = (state_q == LC_VALID) && (secs_q == alarm_q);

  always_comb begin
    state_d = state_q;
    case (state_q)
      LC_INIT:     if (ctrl_q[C_LEAVE_INIT]) state_d = LC_NONVALID;
      LC_NONVALID: if (ctrl_q[C_LEAVE_NV] && (key_q == GLITCH_KEY)) state_d = LC_VALID;
      default:     state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LC_INIT;
      sub_q   <= '0;
      secs_q  <= '0;
      alarm_q <= '0;
      ctrl_q  <= '0;
      key_q   <= '0;
      alp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sub_q   <= sub_q + 1'b1;
      if (ld_secs)         secs_q <= wr_data;
      else if (run && wrap) secs_q <= secs_q + 32'd1;
      if (ld_alarm) alarm_q <= wr_data;
      if (ld_ctrl)  ctrl_q  <= wr_data[15:0] & CTRL_MASK;
      if (ld_key)   key_q   <= wr_data;
      if (match)        alp_q <= 1'b1;
      else if (clr_alp) alp_q <= 1'b0;
    end
  end

  assign secs_o       = secs_q;
  assign sub_o        = sub_q;
  assign alarm_o      = alarm_q;
  assign ctrl_o       = ctrl_q;
  assign key_o        = key_q;
  assign init_done_o  = (state_q != LC_INIT);
  assign nv_done_o    = (state_q == LC_VALID);
  assign alarm_flag_o = alp_q;
  assign irq_o        = alp_q && ctrl_q[C_IRQ_EN];
  assign wake_o       = alp_q && ctrl_q[C_WAKE_EN];

  assert_lc_forward_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LC_VALID) |=> (state_q == LC_VALID));

  assert_key_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LC_VALID && $past(state_q) != LC_VALID) |->
      ($past(key_q) == GLITCH_KEY && $past(state_q) == LC_NONVALID));

  assert_alarm_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alp_q) |-> $past(secs_q == alarm_q && state_q == LC_VALID));

  assert_secs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ld_secs) && !$past(run && wrap)) |-> $stable(secs_q));
endmodule

// File: rtl/lp_rtc.sv
module lp_rtc
  import lp_rtc_pkg::*;
#(
  parameter int SUB_W = 15
) (
  input  logic          bus_clk,
  input  logic          lp_clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic          irq,
  output logic          wake
);
  localparam int WR_W   = AW + 32;
  localparam int SNAP_W = 32 + SUB_W + 32 + 16 + 32 + 3;

  logic            wr_busy, lp_wr_pulse;
  logic [WR_W-1:0] lp_wr_word;

  lp_rtc_xfer #(.W(WR_W)) u_wr_xfer (
    .src_clk  (bus_clk),
    .dst_clk  (lp_clk),
    .rst_n    (rst_n),
    .src_valid(wr_valid),
    .src_busy (wr_busy),
    .src_data ({wr_addr, wr_data}),
    .dst_pulse(lp_wr_pulse),
    .dst_data (lp_wr_word)
  );

  assign wr_ready = !wr_busy;

  logic [31:0]      c_secs, c_alarm, c_key;
  logic [SUB_W-1:0] c_sub;
  logic [15:0]      c_ctrl;
  logic             c_init, c_nv, c_alp;

  lp_rtc_core #(.SUB_W(SUB_W)) u_core (
    .clk         (lp_clk),
    .rst_n       (rst_n),
    .wr_pulse    (lp_wr_pulse),
    .wr_addr     (lp_wr_word[WR_W-1:32]),
    .wr_data     (lp_wr_word[31:0]),
    .secs_o      (c_secs),
    .sub_o       (c_sub),
    .alarm_o     (c_alarm),
    .ctrl_o      (c_ctrl),
    .key_o       (c_key),
    .init_done_o (c_init),
    .nv_done_o   (c_nv),
    .alarm_flag_o(c_alp),
    .irq_o       (irq),
    .wake_o      (wake)
  );

  logic              snap_busy, snap_pulse;
  logic [SNAP_W-1:0] snap_word, snap_q;

  lp_rtc_xfer #(.W(SNAP_W)) u_snap_xfer (
    .src_clk  (lp_clk),
    .dst_clk  (bus_clk),
    .rst_n    (rst_n),
    .src_valid(!snap_busy),
    .src_busy (snap_busy),
    .src_data ({c_secs, c_sub, c_alarm, c_ctrl, c_key, c_init, c_nv, c_alp}),
    .dst_pulse(snap_pulse),
    .dst_data (snap_word)
  );

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n)          snap_q <= '0;
    else if (snap_pulse) snap_q <= snap_word;
  end

  logic [31:0]      s_secs, s_alarm, s_key;
  logic [SUB_W-1:0] s_sub;
  logic [15:0]      s_ctrl;
  logic             s_init, s_nv, s_alp;

  assign {s_secs, s_sub, s_alarm, s_ctrl, s_key, s_init, s_nv, s_alp} = snap_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFS_SECS:  rd_data = s_secs;
      OFS_SUB:   rd_data = 32'(s_sub);
      OFS_ALARM: rd_data = s_alarm;
      OFS_CTRL:  rd_data = {16'h0, s_ctrl};
      OFS_KEY:   rd_data = s_key;
      OFS_STAT: begin
        rd_data[S_INIT_DONE] = s_init;
        rd_data[S_NV_DONE]   = s_nv;
        rd_data[S_ALARM]     = s_alp;
        rd_data[S_BUSY]      = wr_busy;
      end
      default:   rd_data = '0;
    endcase
  end

  // R2: an accepted write closes the port on the following cycle
  assert_ready_drop_R2: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_ready);
endmodule

// File: tb/lp_rtc_test.sv
module lp_rtc_test;
  localparam int SUB_W = 3;
  localparam int SEC_CYC = 1 << SUB_W;

  logic        bus_clk = 1'b0, lp_clk = 1'b0, rst_n = 1'b0;
  logic        wr_valid = 1'b0, wr_ready;
  logic [4:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        irq, wake;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 bus_clk = ~bus_clk;
  always #80 lp_clk  = ~lp_clk;

  lp_rtc #(.SUB_W(SUB_W)) uut (
    .bus_clk(bus_clk), .lp_clk(lp_clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .wake(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input logic [31:0] act,
                         input logic [31:0] lo, input logic [31:0] hi);
    tests++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h..0x%08h", req, act, lo, hi);
    end
  endtask

  task automatic lp_wait(input int n);
    repeat (n) @(posedge lp_clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge bus_clk);
    @(negedge bus_clk);
    wr_valid = 1'b0;
    while (!wr_ready) @(negedge bus_clk);
    lp_wait(2);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    lp_wait(8);
    @(negedge bus_clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, s0;
    logic [7:0]  seen;
    int          k;
    repeat (3) @(posedge lp_clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5'h00, v); chk("R1 secs", v, 0);
    rd(5'h08, v); chk("R1 alarm", v, 0);
    rd(5'h10, v); chk("R1 ctrl", v, 0);
    rd(5'h14, v); chk("R1 status", v, 0);
    rd(5'h18, v); chk("R1 key", v, 0);
    chk("R1 irq/wake", {30'h0, irq, wake}, 0);

    // R8 secs==alarm==0 but block still in init: no flag
    rd(5'h14, v); chk("R8 no flag before valid", v & 32'h8, 0);

    // R3 non-valid exit request ignored in init
    wr(5'h10, 32'h0000_4000);
    rd(5'h14, v); chk("R3 nv request in init", v, 0);

    // R3 leave init with wrong key; R1 ctrl masking
    wr(5'h18, 32'h1234_5678);
    wr(5'h10, 32'hFFFF_8800);
    rd(5'h14, v); chk("R3 init done", v & 32'hC000, 32'h8000);
    rd(5'h10, v); chk("R1 ctrl readback", v, 32'h8800);
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, v); chk("R1 ctrl mask", v, 32'hC898);

    // R4 wrong key blocks; R5 no counting while non-valid
    wr(5'h10, 32'h0000_C808);
    wr(5'h00, 32'd5);
    lp_wait(3 * SEC_CYC);
    rd(5'h14, v); chk("R4 wrong key", v & 32'h4000, 0);
    rd(5'h00, v); chk("R5 frozen while non-valid", v, 5);

    // R4 correct key completes exit
    wr(5'h18, 32'h4173_6166);
    rd(5'h14, v); chk("R4 valid", v & 32'hC000, 32'hC000);
    rd(5'h18, v); chk("R1 key readback", v, 32'h4173_6166);

    // R5 load sweep, counting disabled
    wr(5'h08, 32'hFFFF_FFF0);
    wr(5'h10, 32'h0000_C800);
    for (int i = 0; i < 8; i++) begin
      v = 32'h9E37_79B9 * i + ((i == 7) ? 32'h0 : 32'h1);
      if (i == 6) v = 32'hFFFF_FFFE;
      wr(5'h00, v);
      lp_wait(2 * SEC_CYC);
      rd(5'h00, s0); chk("R5 load hold", s0, v);
    end

    // R7 writes to sub-second register ignored, counter runs
    wr(5'h00, 32'd77);
    wr(5'h04, 32'd5);
    rd(5'h00, v); chk("R7 sub write ignored", v, 77);
    seen = '0;
    for (int i = 0; i < 16; i++) begin
      rd(5'h04, v);
      chk_rng("R7 sub range", v, 0, SEC_CYC - 1);
      seen[v[2:0]] = 1'b1;
    end
    k = $countones(seen);
    chk_rng("R7 sub advances", k, 2, 8);

    // R6 counting rate
    wr(5'h00, 32'd1000);
    wr(5'h10, 32'h0000_C808);
    lp_wait(10 * SEC_CYC);
    rd(5'h00, v); chk_rng("R6 rate", v, 1010, 1012);

    // R6 wrap
    wr(5'h10, 32'h0000_C800);
    wr(5'h00, 32'hFFFF_FFFF);
    wr(5'h10, 32'h0000_C808);
    rd(5'h00, v);
    v = v + 32'd1;
    chk_rng("R6 wrap", v, 1, 3);

    // R2 busy, back-pressure, pending write applied
    wr(5'h10, 32'h0000_C800);
    @(negedge bus_clk);
    wr_valid = 1'b1; wr_addr = 5'h08; wr_data = 32'h0000_1111;
    @(negedge bus_clk);
    chk("R2 ready low", {31'h0, wr_ready}, 0);
    rd_addr = 5'h14;
    #1 chk("R2 busy bit", rd_data & 32'h1, 1);
    wr_data = 32'h0000_2222;
    while (!wr_ready) @(negedge bus_clk);
    @(negedge bus_clk);
    wr_valid = 1'b0;
    while (!wr_ready) @(negedge bus_clk);
    rd(5'h08, v); chk("R2 pending write lands", v, 32'h2222);
    rd(5'h14, v); chk("R2 busy clear", v & 32'h1, 0);

    // R8/R10 alarm with interrupt enabled
    wr(5'h00, 32'd200);
    wr(5'h08, 32'd203);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h10, 32'h0000_C888);
    k = 0;
    while (!irq && k < 12 * SEC_CYC) begin
      @(posedge lp_clk); k++;
    end
    @(negedge bus_clk);
    chk("R10 irq on match", {30'h0, irq, wake}, 32'h2);
    rd(5'h00, v); chk_rng("R8 secs at alarm", v, 203, 206);
    rd(5'h14, v); chk("R8 flag set", v & 32'hC008, 32'hC008);

    // R10 wake routing
    wr(5'h10, 32'h0000_C818);
    @(negedge bus_clk);
    chk("R10 wake only", {30'h0, irq, wake}, 32'h1);

    // R9 write-zero keeps flag; write-one clears
    wr(5'h14, 32'h0000_0000);
    rd(5'h14, v); chk("R9 zero write keeps flag", v & 32'h8, 32'h8);
    wr(5'h14, 32'h0000_0008);
    rd(5'h14, v); chk("R9 flag cleared, lifecycle kept", v & 32'hC008, 32'hC000);
    @(negedge bus_clk);
    chk("R10 outputs low after clear", {30'h0, irq, wake}, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule